// File: doc/BRIEF.md
# Shift and Rotate Operand Unit with Carry

This block transforms a data-path operand word before it reaches an arithmetic unit. It applies one of four shift or rotate operations and reports the bit shifted out as a carry-out flag. When no shift happens, the incoming carry flag passes through unchanged. A 2-bit type field selects the operation. A mode input decides how the amount input is read.

In immediate mode, only the low five bits of the amount count. A zero field in that mode has a special meaning that depends on the type. For the two right shifts it means a shift by the full word width. For rotate it means a one-bit rotate through the carry flag. In register mode, the amount is an already resolved count from 0 to the word width, and the type field always selects one of the four plain operations.

The shifting is combinational. By default, an output register stage with a synchronous active-high reset holds the result, and a valid flag travels alongside it.

Top module: `shc_unit`

## Requirements
- R1: The type field encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. In register mode (`imm_mode` = 0) the amount is the full `sh_amt` value, which ranges from 0 to W.
- R2: When the effective amount is zero, the result equals the operand and the carry-out equals the carry-in.
- R3: A logical left shift by n moves operand bits up and fills zeros at the bottom. For n from 1 to W-1 the carry-out is operand bit W-n. For n = W the result is zero and the carry-out is operand bit 0.
- R4: A logical right shift by n fills zeros at the top, and the carry-out is operand bit n-1. For n = W the result is zero and the carry-out is operand bit W-1.
- R5: An arithmetic right shift by n fills the vacated top bits with operand bit W-1, and the carry-out is operand bit n-1. For n = W every result bit is a copy of operand bit W-1.
- R6: A rotate right by n from 1 to W-1 gives the rotated word, and the carry-out equals result bit W-1. For n = W in register mode the result equals the operand and the carry-out is operand bit W-1.
- R7: In immediate mode (`imm_mode` = 1) the amount is `sh_amt[4:0]`, and `sh_amt[5]` has no effect. For type 1 or type 2, a zero field means a shift by W.
- R8: In immediate mode, type 3 with a zero field selects rotate-through-carry by one. Result bit W-1 takes the carry-in, result bits W-2:0 take operand bits W-1:1, and the carry-out is operand bit 0.
- R9: In register mode, type 3 with amount 0 never selects rotate-through-carry. The operand and the carry-in pass through unchanged.
- R10: With the output stage enabled (default), `result`, `carry_out` and `out_valid` update on the first rising clock edge that samples the inputs. `out_valid` is high exactly when `in_valid` was high at that edge.
- R11: A synchronous reset drives `out_valid`, `result` and `carry_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| imm_mode | input | 1 | 1 = immediate amount decode, 0 = register amount |
| sh_type | input | 2 | Shift type field |
| sh_amt | input | AW+1 (6) | Shift amount; only low AW bits in immediate mode |
| operand | input | W (32) | Data word to shift |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| result | output | W (32) | Shifted word |
| carry_out | output | 1 | Outgoing carry flag |

## Verification
Each result is due one clock edge after its inputs are sampled. The bench drives a new input word on every falling edge and pushes the independently computed expectation into a queue at the same time. The monitor pops and compares on the following falling edge, which is exactly one register delay later. If `out_valid` appears with no pending expectation, or the queue is not empty after the final idle cycle, that is an error. This exposes any latency other than a single cycle.

// File: rtl/shc_pkg.sv
package shc_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  localparam logic [1:0] TY_LSL = 2'd0;
  localparam logic [1:0] TY_LSR = 2'd1;
  localparam logic [1:0] TY_ASR = 2'd2;
  localparam logic [1:0] TY_ROR = 2'd3;

endpackage

// File: rtl/shc_decode.sv
module shc_decode import shc_pkg::*; #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [1:0]  sh_type,
  input  logic        imm_mode,
  input  logic [AW:0] sh_amt,
  output shift_kind_e kind,
  output logic [AW:0] eff_amt
);

  logic [AW-1:0] field;

  always_comb begin
    field   = sh_amt[AW-1:0];
    eff_amt = sh_amt;
    unique case (sh_type)
      TY_LSL:  kind = SK_LSL;
      TY_LSR:  kind = SK_LSR;
      TY_ASR:  kind = SK_ASR;
      default: kind = SK_ROR;
    endcase
    if (imm_mode) begin
      eff_amt = {1'b0, field};
      if (field == '0) begin
        if (sh_type == TY_LSR || sh_type == TY_ASR) begin
          eff_amt = (AW+1)'(W);
        end else if (sh_type == TY_ROR) begin
          kind    = SK_RRX;
          eff_amt = (AW+1)'(1);
        end
      end
    end
  end

endmodule

// File: rtl/shc_core.sv
module shc_core import shc_pkg::*; #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0] operand,
  input  shift_kind_e  kind,
  input  logic [AW:0]  eff_amt,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);

  // One spare bit beside the word catches the last bit shifted out.
  logic [W:0]    lsl_w, lsr_w, asr_w;
  logic [W-1:0]  rot_res;
  logic [AW-1:0] rot_n;

  always_comb begin
    rot_n   = eff_amt[AW-1:0];
    lsl_w   = {1'b0, operand} << eff_amt;
    lsr_w   = {operand, 1'b0} >> eff_amt;
    asr_w   = (W+1)'($signed({operand, 1'b0}) >>> eff_amt);
    rot_res = W'({operand, operand} >> rot_n);
  end

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    if (eff_amt != '0) begin
      unique case (kind)
        SK_LSL: begin result = lsl_w[W-1:0]; carry_out = lsl_w[W]; end
        SK_LSR: begin result = lsr_w[W:1];   carry_out = lsr_w[0]; end
        SK_ASR: begin result = asr_w[W:1];   carry_out = asr_w[0]; end
        SK_ROR: begin result = rot_res;      carry_out = rot_res[W-1]; end
        default: begin
          result    = {carry_in, operand[W-1:1]};
          carry_out = operand[0];
        end
      endcase
    end
  end

endmodule

// File: rtl/shc_stage.sv
module shc_stage #(
  parameter int W = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d_result,
  input  logic         d_carry,
  output logic         q_valid,
  output logic [W-1:0] q_result,
  output logic         q_carry
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q_valid  <= 1'b0;
          q_result <= '0;
          q_carry  <= 1'b0;
        end else begin
          q_valid  <= d_valid;
          q_result <= d_result;
          q_carry  <= d_carry;
        end
      end
    end else begin : g_comb
      assign q_valid  = d_valid;
      assign q_result = d_result;
      assign q_carry  = d_carry;
    end
  endgenerate

endmodule

// File: rtl/shc_unit.sv
module shc_unit import shc_pkg::*; #(
  parameter int W = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int AW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         imm_mode,
  input  logic [1:0]   sh_type,
  input  logic [AW:0]  sh_amt,
  input  logic [W-1:0] operand,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         carry_out
);

  shift_kind_e  kind;
  logic [AW:0]  eff_amt;
  logic [W-1:0] comb_result;
  logic         comb_carry;

  shc_decode #(.W(W)) u_decode (
    .sh_type (sh_type),
    .imm_mode(imm_mode),
    .sh_amt  (sh_amt),
    .kind    (kind),
    .eff_amt (eff_amt)
  );

  shc_core #(.W(W)) u_core (
    .operand  (operand),
    .kind     (kind),
    .eff_amt  (eff_amt),
    .carry_in (carry_in),
    .result   (comb_result),
    .carry_out(comb_carry)
  );

  shc_stage #(.W(W), .OUT_REG(OUT_REG)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_result(comb_result),
    .d_carry (comb_carry),
    .q_valid (out_valid),
    .q_result(result),
    .q_carry (carry_out)
  );

endmodule

// File: rtl/shc_chk.sv
module shc_chk #(
  parameter int W = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int AW = $clog2(W)
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         imm_mode,
  input logic [1:0]   sh_type,
  input logic [AW:0]  sh_amt,
  input logic [W-1:0] operand,
  input logic         carry_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         carry_out
);

  generate
    if (OUT_REG) begin : g_chk
      // R11
      reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !carry_out));

      // R10
      valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

      // R10
      no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

      // R2
      zero_amount_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !imm_mode && sh_amt == '0)
        |=> (result == $past(operand) && carry_out == $past(carry_in)));

      // R8
      rrx_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && imm_mode && sh_type == 2'd3 && sh_amt[AW-1:0] == '0)
        |=> (carry_out == $past(operand[0]) && result[W-1] == $past(carry_in)));

      // R7
      imm_lsr_full_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && imm_mode && sh_type == 2'd1 && sh_amt[AW-1:0] == '0)
        |=> (result == '0 && carry_out == $past(operand[W-1])));

      // R5
      asr_full_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !imm_mode && sh_type == 2'd2 && sh_amt == (AW+1)'(W))
        |=> (result == {W{$past(operand[W-1])}}));
    end
  endgenerate

endmodule

bind shc_unit shc_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/test_shc_unit.sv
module test_shc_unit;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         c;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         imm_mode = 1'b0;
  logic [1:0]   sh_type = '0;
  logic [5:0]   sh_amt = '0;
  logic [W-1:0] operand = '0;
  logic         carry_in = 1'b0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         carry_out;

  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  shc_unit i_shc_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .imm_mode(imm_mode),
    .sh_type(sh_type), .sh_amt(sh_amt), .operand(operand), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
  );

  function automatic logic [W:0] model(input logic [W-1:0] op, input logic [1:0] ty,
                                       input logic imm, input logic [5:0] amt,
                                       input logic cin);
    int n;
    int kind;
    logic [W-1:0] r;
    logic c;
    kind = int'(ty);
    n = int'(amt);
    if (imm) begin
      n = int'(amt[4:0]);
      if (n == 0 && (ty == 2'd1 || ty == 2'd2)) n = W;
      else if (n == 0 && ty == 2'd3) kind = 4;
    end
    r = op;
    c = cin;
    if (kind == 4) begin
      r = {cin, op[W-1:1]};
      c = op[0];
    end else if (n != 0) begin
      for (int i = 0; i < W; i++) begin
        case (kind)
          0: if (i >= n) r[i] = op[i-n]; else r[i] = 1'b0;
          1: if (i + n < W) r[i] = op[i+n]; else r[i] = 1'b0;
          2: if (i + n < W) r[i] = op[i+n]; else r[i] = op[W-1];
          default: r[i] = op[(i+n)%W];
        endcase
      end
      if (kind == 0) c = op[W-n];
      else if (kind == 3) c = r[W-1];
      else c = op[n-1];
    end
    return {c, r};
  endfunction

  task automatic drive(input logic [W-1:0] op, input logic [1:0] ty, input logic imm,
                       input logic [5:0] amt, input logic cin, input string tag);
    exp_t e;
    logic [W:0] m;
    @(negedge clk);
    operand = op; sh_type = ty; imm_mode = imm; sh_amt = amt; carry_in = cin;
    in_valid = 1'b1;
    m = model(op, ty, imm, amt, cin);
    e.res = m[W-1:0];
    e.c = m[W];
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: one result is due one edge after each driven word.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: out_valid with nothing pending (actual 1, expected 0)");
      end else begin
        e = q.pop_front();
        if (result !== e.res || carry_out !== e.c) begin
          n_fail++;
          $display("FAIL %s: result %h carry %b, expected %h carry %b",
                   e.tag, result, carry_out, e.res, e.c);
        end
      end
    end
  end

  function automatic string reg_tag(input logic [1:0] ty, input int a);
    if (a == 0) return (ty == 2'd3) ? "R9" : "R2";
    case (ty)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    // R11: reset with live inputs
    in_valid = 1'b1; operand = 32'hdead_beef; sh_amt = 6'd3; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: valid %b result %h carry %b, expected 0 0 0",
               out_valid, result, carry_out);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // Directed corner cases
    drive(32'h8000_0001, 2'd1, 1'b1, 6'd0,  1'b0, "R7");   // LSR by 32
    drive(32'h8000_0010, 2'd2, 1'b1, 6'd0,  1'b0, "R5");   // ASR by 32
    drive(32'h7fff_fffe, 2'd2, 1'b1, 6'd0,  1'b1, "R5");   // ASR by 32 positive
    drive(32'h0000_0003, 2'd3, 1'b1, 6'd0,  1'b0, "R8");   // RRX cin 0
    drive(32'h1234_5678, 2'd3, 1'b1, 6'd0,  1'b1, "R8");   // RRX cin 1
    drive(32'hffff_0001, 2'd3, 1'b0, 6'd0,  1'b1, "R9");   // reg rotate 0
    drive(32'hc000_0000, 2'd1, 1'b1, 6'h20, 1'b0, "R7");   // bit 5 ignored
    drive(32'h0000_00f0, 2'd0, 1'b1, 6'h24, 1'b1, "R7");   // bit 5 ignored
    drive(32'h0000_0001, 2'd0, 1'b0, 6'd32, 1'b0, "R3");   // LSL by 32
    drive(32'h8000_0000, 2'd3, 1'b0, 6'd32, 1'b0, "R6");   // ROR by 32

    // Register-mode sweep (R1)
    for (int ty = 0; ty < 4; ty++)
      for (int a = 0; a <= 32; a++)
        for (int ci = 0; ci < 2; ci++)
          drive($urandom, 2'(ty), 1'b0, 6'(a), 1'(ci), reg_tag(2'(ty), a));

    // Immediate-mode sweep
    for (int ty = 0; ty < 4; ty++)
      for (int a = 0; a < 32; a++)
        for (int ci = 0; ci < 2; ci++)
          drive($urandom, 2'(ty), 1'b1, {1'($urandom), 5'(a)}, 1'(ci),
                (ty == 3 && a == 0) ? "R8" : "R7");

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R10: idle input gives idle output, nothing left pending
    n_tests++;
    if (out_valid !== 1'b0 || q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: valid %b pending %0d, expected 0 0", out_valid, q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule